// File: doc/BRIEF.md
# Synchronous PWM Channel Update Controller

This block holds double-buffered settings for a group of PWM channels that must all change on the same PWM period boundary. Duty-cycle words arrive one at a time from a DMA-style write stream. Each word lands in the shadow register of the next channel that belongs to the synchronous group, in ascending channel order. A down-counter runs on the PWM period-end pulse. When it expires, every shadow duty value and the buffered update-period value move into the active registers in a single cycle.

Period and dead-time shadows follow a separate path. They reach the active registers only on a period boundary that comes while software holds an unlock bit, and the unlock bit clears itself once that commit has happened. Four status flags report write-ready, transfer-complete, buffer-empty and underrun. A mask decides which flags drive the interrupt line.

Top module: `sync_upd_ctrl`

## Requirements
- R1: With update-period shadow value N written through `upr_wr`, the duty commit after a commit comes on the (N+1)th `period_end` pulse. At each commit `upr_act` takes the shadow value. After reset the counter is 0, so the first `period_end` commits.
- R2: `duty_act` changes only in the cycle after `duty_commit`. At that point every channel slice takes its shadow value together.
- R3: Duty words go to the channels whose `sync_en` bit is 1, in ascending index order, and channels with a 0 bit are skipped. After the highest enabled channel is written, the next word goes to the lowest enabled channel. Every duty commit moves the pointer back to the lowest enabled channel. When `sync_en` is 0, duty words are ignored.
- R4: Period and dead-time shadows written through `cfg_wr` reach `per_act`/`dt_act` only on a `period_end` while `unlock_q` is 1. They reach only the channels whose `sync_en` bit is 1. Without the unlock bit they are never applied.
- R5: `unlock_set` sets `unlock_q`. It then holds 1 until the period/dead-time commit and reads 0 after it.
- R6: `status` bit 0 (write-ready) is set at every duty commit and cleared by `stat_rd`. A set in the same cycle as a read wins.
- R7: `status` bit 3 (underrun) is set at a duty commit when at least one channel is enabled and the highest enabled channel has not been written since the previous commit. `stat_rd` clears it.
- R8: `status` bit 1 (transfer-complete) is set by a `dma_end` pulse and cleared by `stat_rd`. `status` bit 2 (buffer-empty) follows `dma_idle`.
- R9: `irq` is 1 exactly when some `status` bit is 1 and the matching `irq_mask` bit is also 1.
- R10: After reset, all active and shadow values, the update-period value, `unlock_q` and the sticky flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_en | input | NCH | Channels that belong to the synchronous group |
| period_end | input | 1 | One-cycle pulse at the end of each PWM period |
| duty_wr | input | 1 | Duty word strobe from the write stream |
| duty_wdata | input | DUTY_W | Duty word |
| upr_wr | input | 1 | Write strobe for the update-period shadow |
| upr_wdata | input | UPR_W | Update-period value (N gives N+1 periods) |
| cfg_wr | input | 1 | Write strobe for a channel's period/dead-time shadow |
| cfg_ch | input | CH_W | Channel index for `cfg_wr` |
| cfg_per | input | PER_W | Period shadow value |
| cfg_dt | input | DT_W | Dead-time shadow value |
| unlock_set | input | 1 | Arms the period/dead-time commit |
| dma_end | input | 1 | Pulse when a block transfer finishes |
| dma_idle | input | 1 | High while no transfer is pending |
| stat_rd | input | 1 | Status read strobe, clears the sticky flags |
| irq_mask | input | 4 | Interrupt enable per status bit |
| duty_act | output | NCH*DUTY_W | Active duty values, channel 0 in the low slice |
| per_act | output | NCH*PER_W | Active period values |
| dt_act | output | NCH*DT_W | Active dead-time values |
| upr_act | output | UPR_W | Active update-period value |
| unlock_q | output | 1 | Unlock bit readback |
| duty_commit | output | 1 | Duty commit in this cycle |
| perdt_commit | output | 1 | Period/dead-time commit in this cycle |
| status | output | 4 | {underrun, buffer-empty, transfer-complete, write-ready} |
| irq | output | 1 | Masked interrupt |

## Verification
A miscounting update-period counter moves the duty commit off the expected period pulse. The next `period_end` then either produces a commit that the scoreboard has no entry for, or leaves an entry unconsumed, so the error shows within one PWM period. A channel pointer that skips, fails to wrap or fails to reset shows up as a wrong slice of `duty_act` at the next commit. It also shows up as a wrong underrun bit read right after that commit. A stuck unlock bit appears at the very next period boundary, either as period values that never arrive or as values that arrive without being armed.

// File: rtl/sup_pkg.sv
package sup_pkg;
  localparam int unsigned FLG_WRDY  = 0;
  localparam int unsigned FLG_DONE  = 1;
  localparam int unsigned FLG_EMPTY = 2;
  localparam int unsigned FLG_UNDER = 3;
  localparam int unsigned FLG_N     = 4;
endpackage

// File: rtl/sup_timer.sv
// Update-period down-counter: commits on the (N+1)th period pulse.
module sup_timer #(
  parameter int UPR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             period_end,
  input  logic             upr_wr,
  input  logic [UPR_W-1:0] upr_wdata,
  output logic             commit,
  output logic [UPR_W-1:0] upr_act
);
  logic [UPR_W-1:0] cnt_q, cnt_d;
  logic [UPR_W-1:0] sh_q;
  logic [UPR_W-1:0] act_d;
  logic             cnt_en;

  always_comb begin
    commit = period_end && (cnt_q == '0);
    cnt_en = period_end;
    cnt_d  = commit ? sh_q : (cnt_q - 1'b1);
    act_d  = sh_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      sh_q    <= '0;
      upr_act <= '0;
    end else begin
      if (cnt_en) cnt_q   <= cnt_d;
      if (upr_wr) sh_q    <= upr_wdata;
      if (commit) upr_act <= act_d;
    end
  end
endmodule

// File: rtl/sup_duty_seq.sv
// Duty shadow registers with ordered channel pointer.
module sup_duty_seq #(
  parameter int NCH    = 4,
  parameter int DUTY_W = 16,
  parameter int CH_W   = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NCH-1:0]          sync_en,
  input  logic                    duty_wr,
  input  logic [DUTY_W-1:0]       duty_wdata,
  input  logic                    commit,
  output logic [NCH*DUTY_W-1:0]   duty_act,
  output logic                    set_short
);
  logic [CH_W-1:0] ptr_q, ptr_d, lo, hi, nxt, tgt;
  logic            started_q, started_d;
  logic            full_q, full_d;
  logic            any_en, wr_ok;

  always_comb begin
    any_en = |sync_en;
    lo     = '0;
    hi     = '0;
    for (int i = NCH-1; i >= 0; i--) if (sync_en[i]) lo = CH_W'(i);
    for (int i = 0; i < NCH; i++)    if (sync_en[i]) hi = CH_W'(i);
    nxt = lo;
    for (int i = NCH-1; i >= 0; i--)
      if (sync_en[i] && (CH_W'(i) > ptr_q)) nxt = CH_W'(i);
    tgt   = started_q ? nxt : lo;
    wr_ok = duty_wr && any_en;
  end

  always_comb begin
    ptr_d     = ptr_q;
    started_d = started_q;
    full_d    = full_q;
    if (commit) begin
      started_d = 1'b0;
      full_d    = 1'b0;
    end else if (wr_ok) begin
      ptr_d = tgt;
      if (tgt == hi) begin
        started_d = 1'b0;
        full_d    = 1'b1;
      end else begin
        started_d = 1'b1;
      end
    end
    set_short = any_en && !full_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q     <= '0;
      started_q <= 1'b0;
      full_q    <= 1'b0;
    end else begin
      ptr_q     <= ptr_d;
      started_q <= started_d;
      full_q    <= full_d;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [DUTY_W-1:0] sh_q, act_q;
    logic              we;
    assign we = wr_ok && (tgt == CH_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_q  <= '0;
        act_q <= '0;
      end else begin
        if (we)     sh_q  <= duty_wdata;
        if (commit) act_q <= sh_q;
      end
    end
    assign duty_act[g*DUTY_W +: DUTY_W] = act_q;
  end
endmodule

// File: rtl/sup_perdt_bank.sv
// Period and dead-time shadows, committed under a self-clearing unlock bit.
module sup_perdt_bank #(
  parameter int NCH   = 4,
  parameter int PER_W = 16,
  parameter int DT_W  = 8,
  parameter int CH_W  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCH-1:0]        sync_en,
  input  logic                  period_end,
  input  logic                  cfg_wr,
  input  logic [CH_W-1:0]       cfg_ch,
  input  logic [PER_W-1:0]      cfg_per,
  input  logic [DT_W-1:0]       cfg_dt,
  input  logic                  unlock_set,
  output logic [NCH*PER_W-1:0]  per_act,
  output logic [NCH*DT_W-1:0]   dt_act,
  output logic                  unlock_q,
  output logic                  commit
);
  logic unlock_d;

  always_comb begin
    commit   = period_end && unlock_q;
    unlock_d = unlock_set || (unlock_q && !commit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) unlock_q <= 1'b0;
    else        unlock_q <= unlock_d;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [PER_W-1:0] per_sh, per_a;
    logic [DT_W-1:0]  dt_sh, dt_a;
    logic             we, ce;
    assign we = cfg_wr && (cfg_ch == CH_W'(g));
    assign ce = commit && sync_en[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        per_sh <= '0;
        dt_sh  <= '0;
        per_a  <= '0;
        dt_a   <= '0;
      end else begin
        if (we) begin
          per_sh <= cfg_per;
          dt_sh  <= cfg_dt;
        end
        if (ce) begin
          per_a <= per_sh;
          dt_a  <= dt_sh;
        end
      end
    end
    assign per_act[g*PER_W +: PER_W] = per_a;
    assign dt_act[g*DT_W +: DT_W]    = dt_a;
  end
endmodule

// File: rtl/sup_status.sv
// Sticky status flags and masked interrupt.
module sup_status
  import sup_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             duty_commit,
  input  logic             set_short,
  input  logic             dma_end,
  input  logic             dma_idle,
  input  logic             stat_rd,
  input  logic [FLG_N-1:0] irq_mask,
  output logic [FLG_N-1:0] status,
  output logic             irq
);
  logic wrdy_q, wrdy_d, done_q, done_d, under_q, under_d;

  always_comb begin
    wrdy_d  = duty_commit || (wrdy_q && !stat_rd);
    under_d = (duty_commit && set_short) || (under_q && !stat_rd);
    done_d  = dma_end || (done_q && !stat_rd);
    status            = '0;
    status[FLG_WRDY]  = wrdy_q;
    status[FLG_DONE]  = done_q;
    status[FLG_EMPTY] = dma_idle;
    status[FLG_UNDER] = under_q;
    irq = |(status & irq_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrdy_q  <= 1'b0;
      done_q  <= 1'b0;
      under_q <= 1'b0;
    end else begin
      wrdy_q  <= wrdy_d;
      done_q  <= done_d;
      under_q <= under_d;
    end
  end
endmodule

// File: rtl/sync_upd_ctrl.sv
module sync_upd_ctrl
  import sup_pkg::*;
#(
  parameter  int NCH    = 4,
  parameter  int DUTY_W = 16,
  parameter  int PER_W  = 16,
  parameter  int DT_W   = 8,
  parameter  int UPR_W  = 4,
  localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCH-1:0]        sync_en,
  input  logic                  period_end,
  input  logic                  duty_wr,
  input  logic [DUTY_W-1:0]     duty_wdata,
  input  logic                  upr_wr,
  input  logic [UPR_W-1:0]      upr_wdata,
  input  logic                  cfg_wr,
  input  logic [CH_W-1:0]       cfg_ch,
  input  logic [PER_W-1:0]      cfg_per,
  input  logic [DT_W-1:0]       cfg_dt,
  input  logic                  unlock_set,
  input  logic                  dma_end,
  input  logic                  dma_idle,
  input  logic                  stat_rd,
  input  logic [FLG_N-1:0]      irq_mask,
  output logic [NCH*DUTY_W-1:0] duty_act,
  output logic [NCH*PER_W-1:0]  per_act,
  output logic [NCH*DT_W-1:0]   dt_act,
  output logic [UPR_W-1:0]      upr_act,
  output logic                  unlock_q,
  output logic                  duty_commit,
  output logic                  perdt_commit,
  output logic [FLG_N-1:0]      status,
  output logic                  irq
);
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  logic       set_short;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  sup_timer #(.UPR_W(UPR_W)) u_timer (
    .clk(clk), .rst_n(rst_ni), .period_end(period_end),
    .upr_wr(upr_wr), .upr_wdata(upr_wdata),
    .commit(duty_commit), .upr_act(upr_act)
  );

  sup_duty_seq #(.NCH(NCH), .DUTY_W(DUTY_W), .CH_W(CH_W)) u_duty (
    .clk(clk), .rst_n(rst_ni), .sync_en(sync_en),
    .duty_wr(duty_wr), .duty_wdata(duty_wdata), .commit(duty_commit),
    .duty_act(duty_act), .set_short(set_short)
  );

  sup_perdt_bank #(.NCH(NCH), .PER_W(PER_W), .DT_W(DT_W), .CH_W(CH_W)) u_perdt (
    .clk(clk), .rst_n(rst_ni), .sync_en(sync_en), .period_end(period_end),
    .cfg_wr(cfg_wr), .cfg_ch(cfg_ch), .cfg_per(cfg_per), .cfg_dt(cfg_dt),
    .unlock_set(unlock_set), .per_act(per_act), .dt_act(dt_act),
    .unlock_q(unlock_q), .commit(perdt_commit)
  );

  sup_status u_status (
    .clk(clk), .rst_n(rst_ni), .duty_commit(duty_commit), .set_short(set_short),
    .dma_end(dma_end), .dma_idle(dma_idle), .stat_rd(stat_rd),
    .irq_mask(irq_mask), .status(status), .irq(irq)
  );
endmodule

// File: rtl/sync_upd_ctrl_chk.sv
module sync_upd_ctrl_chk #(
  parameter int NCH    = 4,
  parameter int DUTY_W = 16,
  parameter int PER_W  = 16,
  parameter int DT_W   = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  period_end,
  input logic                  unlock_set,
  input logic [3:0]            irq_mask,
  input logic [NCH*DUTY_W-1:0] duty_act,
  input logic [NCH*PER_W-1:0]  per_act,
  input logic [NCH*DT_W-1:0]   dt_act,
  input logic                  unlock_q,
  input logic                  duty_commit,
  input logic                  perdt_commit,
  input logic [3:0]            status,
  input logic                  irq
);
  a_r1_commit_on_period: assert property (@(posedge clk) disable iff (!rst_n)
    duty_commit |-> period_end);
  a_r2_duty_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !duty_commit |=> $stable(duty_act));
  a_r4_perdt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !perdt_commit |=> ($stable(per_act) && $stable(dt_act)));
  a_r5_unlock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (unlock_q && !period_end) |=> unlock_q);
  a_r5_unlock_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (perdt_commit && !unlock_set) |=> !unlock_q);
  a_r6_wrdy_set: assert property (@(posedge clk) disable iff (!rst_n)
    duty_commit |=> status[0]);
  a_r9_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mask == 4'b0) |-> !irq);
endmodule

bind sync_upd_ctrl sync_upd_ctrl_chk #(
  .NCH(NCH), .DUTY_W(DUTY_W), .PER_W(PER_W), .DT_W(DT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .period_end(period_end), .unlock_set(unlock_set),
  .irq_mask(irq_mask), .duty_act(duty_act), .per_act(per_act), .dt_act(dt_act),
  .unlock_q(unlock_q), .duty_commit(duty_commit), .perdt_commit(perdt_commit),
  .status(status), .irq(irq)
);

// File: tb/test_sync_upd_ctrl.sv
module test_sync_upd_ctrl;
  localparam int CLK_P = 10;
  localparam int NCH = 4, DUTY_W = 16, PER_W = 16, DT_W = 8, UPR_W = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic [NCH-1:0] sync_en;
  logic period_end, duty_wr, upr_wr, cfg_wr, unlock_set, dma_end, dma_idle, stat_rd;
  logic [DUTY_W-1:0] duty_wdata;
  logic [UPR_W-1:0] upr_wdata;
  logic [1:0] cfg_ch;
  logic [PER_W-1:0] cfg_per;
  logic [DT_W-1:0] cfg_dt;
  logic [3:0] irq_mask;
  logic [NCH*DUTY_W-1:0] duty_act;
  logic [NCH*PER_W-1:0] per_act;
  logic [NCH*DT_W-1:0] dt_act;
  logic [UPR_W-1:0] upr_act;
  logic unlock_q, duty_commit, perdt_commit, irq;
  logic [3:0] status;

  always #(CLK_P/2) clk = ~clk;

  sync_upd_ctrl i_sync_upd_ctrl (.*);

  int n_chk = 0, n_err = 0;
  logic [NCH*DUTY_W-1:0] exp_q[$];
  logic [NCH*DUTY_W-1:0] exp_sh;
  int m_cnt = 0, m_upr = 0;
  logic seen = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected duty vector at each observed commit
  always @(posedge clk) seen <= rst_n && duty_commit;
  always @(negedge clk) begin
    if (seen) begin
      if (exp_q.size() == 0) chk(1'b0, "R1 unexpected duty commit", 64'd1, 64'd0);
      else begin
        logic [NCH*DUTY_W-1:0] e;
        e = exp_q.pop_front();
        chk(duty_act == e, "R2/R3 duty_act at commit", duty_act, e);
      end
    end
  end

  task automatic set_ch(input int ch, input logic [DUTY_W-1:0] v);
    exp_sh[ch*DUTY_W +: DUTY_W] = v;
  endtask

  task automatic tick(input bit rd = 1'b0);
    @(negedge clk);
    period_end = 1'b1; stat_rd = rd;
    if (m_cnt == 0) begin exp_q.push_back(exp_sh); m_cnt = m_upr; end
    else m_cnt--;
    @(negedge clk);
    period_end = 1'b0; stat_rd = 1'b0;
    #1;
    chk(exp_q.size() == 0, "R1 commit timing", 64'(exp_q.size()), 64'd0);
  endtask

  task automatic wr_duty(input logic [DUTY_W-1:0] v);
    @(negedge clk); duty_wr = 1'b1; duty_wdata = v;
    @(negedge clk); duty_wr = 1'b0; #1;
  endtask

  task automatic wr_upr(input int v);
    @(negedge clk); upr_wr = 1'b1; upr_wdata = UPR_W'(v); m_upr = v;
    @(negedge clk); upr_wr = 1'b0; #1;
  endtask

  task automatic wr_cfg(input int ch, input logic [PER_W-1:0] p, input logic [DT_W-1:0] d);
    @(negedge clk); cfg_wr = 1'b1; cfg_ch = 2'(ch); cfg_per = p; cfg_dt = d;
    @(negedge clk); cfg_wr = 1'b0; #1;
  endtask

  task automatic pulse_rd();
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0; #1;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_err++;
    $display("FAIL R1 watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; sync_en = '0; period_end = 0; duty_wr = 0; upr_wr = 0; cfg_wr = 0;
    unlock_set = 0; dma_end = 0; dma_idle = 0; stat_rd = 0; duty_wdata = '0;
    upr_wdata = '0; cfg_ch = '0; cfg_per = '0; cfg_dt = '0; irq_mask = '0; exp_sh = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    // R10 reset state
    chk(status == 4'b0 && !irq, "R10 status after reset", 64'(status), 64'd0);
    chk(duty_act == '0 && per_act == '0 && dt_act == '0, "R10 actives after reset", duty_act, 64'd0);
    chk(!unlock_q && upr_act == '0, "R10 unlock/upr after reset", 64'(unlock_q), 64'd0);

    sync_en = 4'b1011;
    wr_upr(2);
    tick();                                   // R1 first pulse commits
    chk(upr_act == 4'd2, "R1 upr_act committed", 64'(upr_act), 64'd2);
    chk(status == 4'b1001, "R6/R7 wrdy and underrun after empty set", 64'(status), 64'h9);
    pulse_rd();
    chk(status == 4'b0000, "R6/R7 cleared by read", 64'(status), 64'h0);

    // R3 ordered fill 0,1,3
    wr_duty(16'h100); wr_duty(16'h101); wr_duty(16'h103);
    set_ch(0, 16'h100); set_ch(1, 16'h101); set_ch(3, 16'h103);
    tick();
    chk(duty_act == '0, "R2 duty held before commit", duty_act, 64'd0);
    tick(); tick();
    chk(status == 4'b0001, "R7 no underrun on full set", 64'(status), 64'h1);
    pulse_rd();

    // R3 wrap after highest enabled channel
    wr_duty(16'h200); wr_duty(16'h201); wr_duty(16'h203); wr_duty(16'h210); wr_duty(16'h211);
    set_ch(0, 16'h210); set_ch(1, 16'h211); set_ch(3, 16'h203);
    tick(); tick(); tick();
    chk(status == 4'b0001, "R7 no underrun after wrap", 64'(status), 64'h1);
    pulse_rd();

    // R3 pointer reset at commit, R7 partial set
    wr_duty(16'h300);
    set_ch(0, 16'h300);
    tick(); tick(); tick();
    chk(status == 4'b1001, "R7 underrun on partial set", 64'(status), 64'h9);
    pulse_rd();
    wr_duty(16'h400); wr_duty(16'h401); wr_duty(16'h403);
    set_ch(0, 16'h400); set_ch(1, 16'h401); set_ch(3, 16'h403);
    tick(); tick(); tick();
    pulse_rd();

    // R3 no enabled channel: writes ignored, R7 no underrun
    sync_en = 4'b0000;
    wr_duty(16'h555);
    tick(); tick(); tick();
    chk(status == 4'b0001, "R7 no underrun with empty group", 64'(status), 64'h1);
    pulse_rd();
    sync_en = 4'b1011;

    // R4/R5 period and dead-time under unlock
    wr_cfg(0, 16'h1000, 8'h10);
    wr_cfg(2, 16'h1002, 8'h12);
    tick();
    chk(per_act == '0 && dt_act == '0, "R4 locked without unlock", per_act, 64'd0);
    @(negedge clk); unlock_set = 1'b1; @(negedge clk); unlock_set = 1'b0; #1;
    chk(unlock_q, "R5 unlock set", 64'(unlock_q), 64'd1);
    repeat (3) @(negedge clk); #1;
    chk(unlock_q, "R5 unlock held until period", 64'(unlock_q), 64'd1);
    tick();
    chk(per_act == 64'h0000_0000_0000_1000, "R4 period applied to sync channel only",
        per_act, 64'h1000);
    chk(dt_act == 32'h0000_0010, "R4 dead-time applied", 64'(dt_act), 64'h10);
    chk(!unlock_q, "R5 unlock cleared after commit", 64'(unlock_q), 64'd0);
    wr_cfg(0, 16'h2000, 8'h20);
    tick(); tick();
    chk(per_act[15:0] == 16'h1000, "R4 no apply without new unlock", 64'(per_act[15:0]), 64'h1000);
    pulse_rd();

    // R8/R9 DMA flags and interrupt
    dma_idle = 1'b1; #1;
    chk(status[2] && !irq, "R8/R9 empty flag, masked", 64'(status), 64'h4);
    irq_mask = 4'b0100; #1;
    chk(irq, "R9 irq on enabled empty flag", 64'(irq), 64'd1);
    @(negedge clk); dma_end = 1'b1; @(negedge clk); dma_end = 1'b0; #1;
    irq_mask = 4'b0010; #1;
    chk(status[1] && irq, "R8/R9 transfer-complete flag", 64'(status), 64'h6);
    pulse_rd();
    chk(!status[1] && !irq, "R8/R9 complete cleared by read", 64'(status), 64'h4);
    dma_idle = 1'b0; irq_mask = 4'b0;

    // R1 new update period takes effect after commit
    wr_upr(0);
    repeat (4) tick();
    chk(upr_act == 4'd0, "R1 new upr committed", 64'(upr_act), 64'd0);
    // R6 set wins over same-cycle read
    tick(1'b1);
    chk(status[0], "R6 set beats read", 64'(status), 64'h1);

    repeat (2) @(negedge clk); #1;
    chk(exp_q.size() == 0, "R2 scoreboard drained", 64'(exp_q.size()), 64'd0);
    finish_run();
  end
endmodule